// File: doc/BRIEF.md
# Configurable-Associativity Read Cache

A small read-only byte cache placed between a load port and a built-in backing memory model. One engine holds a fixed number of lines, by default four lines of two bytes each, addressed by 5-bit byte addresses. The parameter `WAYS` arranges those lines three ways. With 1 it is direct-mapped, with 2 it is two-way set-associative, and with the line count it is fully associative. The total storage stays the same in every arrangement.

A load is started by raising `req_valid` for one cycle with a byte address. The block looks up the tags over a modelled two-cycle lookup. On a hit it returns the byte. On a miss it waits out a modelled burst fill, installs the whole aligned byte pair that holds the address, and then returns the byte. Each load ends with a one-cycle `rsp_done` pulse that carries the byte and a hit flag. Saturating hit and miss counters are visible at the ports, so a fixed trace can be compared against known counts.

The controller has four states. IDLE accepts a strobe and goes to LOOKUP. LOOKUP runs its tag-check timer and then goes to RESPOND on a hit or to FILL on a miss. FILL runs the fill timer and installs the line on its last cycle, then goes to RESPOND. RESPOND drives the done pulse and returns to IDLE.

Top module: `assoc_read_cache`

## Requirements
- R1: After reset `rsp_done`, `rsp_hit`, `rsp_data`, `hit_count` and `miss_count` are all zero, and every line is invalid, so the first load of any address misses.
- R2: The byte offset is address bit 0. With WAYS=1 the line index is bits [2:1] and the tag is bits [4:3]. With WAYS=2 the set is bit [1] and the tag is bits [4:2]. With WAYS=4 there is no index and the tag is bits [4:1].
- R3: A load hits only when a valid way of its set holds a matching tag. Address bit 0 then selects the low (0) or high (1) byte of that line, which is returned on `rsp_data`.
- R4: A miss installs the aligned byte pair containing the address, taken from backing memory. Backing byte i, for i from 0 to 31, is the low 8 bits of 100+10*i. For example, byte 5 is 150 and byte 20 is 44.
- R5: When a set has an invalid way, a fill always uses an invalid way. Otherwise it replaces the least recently used way. Hits and fills both mark the way as most recently used.
- R6: Starting from an empty cache, the load trace 1,5,1,4,0,12,5,12,5,12,5 gives 3 hits and 8 misses with WAYS=1, 7 hits and 4 misses with WAYS=2, and 8 hits and 3 misses with WAYS=4.
- R7: Counting the clock edge that samples the strobe as edge 1, `rsp_done` is high after edge 3 on a hit. On a miss it is high after edge 3+50+3*(bytes per line-1), which is 56 by default.
- R8: `rsp_done` is high for exactly one cycle per accepted load, and `rsp_data` and `rsp_hit` are valid in that cycle.
- R9: A strobe raised during LOOKUP, FILL or RESPOND is ignored. It produces no response and changes no counter.
- R10: `hit_count` and `miss_count` each rise by one per hit or miss and saturate at 2^CNT_W-1, which is 255 by default.
- R11: A hit changes no stored line data, so repeated hits to an address return the same byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Load strobe, sampled in IDLE only |
| req_addr | input | ADDR_W | Byte address of the load |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_data | output | 8 | Loaded byte, valid with rsp_done |
| rsp_hit | output | 1 | 1 if the load hit, valid with rsp_done |
| hit_count | output | CNT_W | Saturating hit counter |
| miss_count | output | CNT_W | Saturating miss counter |

## Verification
The assertions check four things on every cycle:
- the done pulse is one cycle wide;
- the counters step by exactly one in the cycle a result appears and never go down;
- no two ways of a set match the same tag;
- stored line data moves only when a fill writes it, and a fill never passes over an invalid way.

Only the bench's scenarios can show the rest:
- that the three arrangements reproduce the trace counts;
- that the victim really is the least recently used way;
- the exact hit and miss latencies;
- that a strobe arriving while busy is dropped;
- counter saturation after hundreds of hits.

// File: rtl/rcache_pkg.sv
package rcache_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOOKUP,
        ST_FILL,
        ST_RESP
    } cstate_t;

    // Backing memory contents: low byte of 100 + 10*i
    function automatic logic [7:0] backing_byte(input int unsigned a);
        return 8'((100 + 10 * a) % 256);
    endfunction

endpackage

// File: rtl/rcache_backing.sv
module rcache_backing #(
    parameter int ADDR_W    = 5,
    parameter int BLK_BYTES = 2,
    localparam int OFF_W    = $clog2(BLK_BYTES),
    localparam int BLK_AW   = ADDR_W - OFF_W,
    localparam int LINE_W   = 8 * BLK_BYTES
) (
    input  logic [BLK_AW-1:0] blk_addr,
    output logic [LINE_W-1:0] line
);
    import rcache_pkg::*;

    for (genvar b = 0; b < BLK_BYTES; b++) begin : g_byte
        assign line[b*8 +: 8] = backing_byte((32'(blk_addr) << OFF_W) + 32'(b));
    end

endmodule

// File: rtl/rcache_store.sv
module rcache_store #(
    parameter int LINES  = 4,
    parameter int WAYS   = 2,
    parameter int TAG_W  = 3,
    parameter int LINE_W = 16,
    localparam int SETS    = LINES / WAYS,
    localparam int SET_W   = (SETS > 1) ? $clog2(SETS) : 1,
    localparam int WAY_W   = (WAYS > 1) ? $clog2(WAYS) : 1,
    localparam int AGE_W   = WAY_W,
    localparam int LINE_IW = (LINES > 1) ? $clog2(LINES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SET_W-1:0]  set_idx,
    input  logic [TAG_W-1:0]  look_tag,
    output logic              hit,
    output logic [WAY_W-1:0]  hit_way,
    output logic [LINE_W-1:0] rd_line,
    output logic [WAY_W-1:0]  victim_way,
    input  logic              touch_en,
    input  logic [WAY_W-1:0]  touch_way,
    input  logic              fill_we,
    input  logic [TAG_W-1:0]  fill_tag,
    input  logic [LINE_W-1:0] fill_line
);

    logic [LINES-1:0]             valid_q;
    logic [LINES-1:0][TAG_W-1:0]  tag_q;
    logic [LINES-1:0][LINE_W-1:0] data_q;
    logic [LINES-1:0][AGE_W-1:0]  age_q;

    logic [WAYS-1:0] way_hit;
    logic [WAYS-1:0] way_inv;
    logic            vic_found;
    logic [AGE_W-1:0] t_age;

    function automatic logic [LINE_IW-1:0] lidx(input logic [SET_W-1:0] s, input int w);
        return LINE_IW'(32'(s) * WAYS + w);
    endfunction

    // Tag compare across the ways of the addressed set
    always_comb begin
        way_hit = '0;
        way_inv = '0;
        hit_way = '0;
        rd_line = '0;
        for (int w = 0; w < WAYS; w++) begin
            way_inv[w] = !valid_q[lidx(set_idx, w)];
            way_hit[w] = valid_q[lidx(set_idx, w)] && (tag_q[lidx(set_idx, w)] == look_tag);
            if (way_hit[w]) begin
                hit_way = WAY_W'(w);
                rd_line = data_q[lidx(set_idx, w)];
            end
        end
    end
    assign hit = |way_hit;

    // Victim: lowest invalid way first, else the oldest way
    always_comb begin
        victim_way = '0;
        vic_found  = 1'b0;
        for (int w = 0; w < WAYS; w++) begin
            if (way_inv[w] && !vic_found) begin
                victim_way = WAY_W'(w);
                vic_found  = 1'b1;
            end
        end
        if (!vic_found) begin
            for (int w = 0; w < WAYS; w++) begin
                if (age_q[lidx(set_idx, w)] == AGE_W'(WAYS - 1)) begin
                    victim_way = WAY_W'(w);
                end
            end
        end
    end

    assign t_age = age_q[lidx(set_idx, int'(touch_way))];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            tag_q   <= '0;
            data_q  <= '0;
            for (int l = 0; l < LINES; l++) begin
                age_q[l] <= AGE_W'(l % WAYS);
            end
        end else begin
            if (touch_en) begin
                for (int w = 0; w < WAYS; w++) begin
                    if (WAY_W'(w) == touch_way) begin
                        age_q[lidx(set_idx, w)] <= '0;
                    end else if (age_q[lidx(set_idx, w)] < t_age) begin
                        age_q[lidx(set_idx, w)] <= age_q[lidx(set_idx, w)] + 1'b1;
                    end
                end
            end
            if (fill_we) begin
                valid_q[lidx(set_idx, int'(touch_way))] <= 1'b1;
                tag_q[lidx(set_idx, int'(touch_way))]   <= fill_tag;
                data_q[lidx(set_idx, int'(touch_way))]  <= fill_line;
            end
        end
    end

    // R2: a tag appears in at most one way of a set
    a_r2_unique_tag: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(way_hit));

    // R11: stored data only moves on a fill
    a_r11_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !fill_we |=> $stable(data_q));

    // R5: a fill never passes over an invalid way
    a_r5_invalid_first: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_we && (|way_inv)) |-> !valid_q[lidx(set_idx, int'(touch_way))]);

endmodule

// File: rtl/assoc_read_cache.sv
module assoc_read_cache #(
    parameter int WAYS       = 2,
    parameter int ADDR_W     = 5,
    parameter int LINES      = 4,
    parameter int BLK_BYTES  = 2,
    parameter int LOOKUP_CYC = 2,
    parameter int FIRST_CYC  = 50,
    parameter int NEXT_CYC   = 3,
    parameter int CNT_W      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              rsp_done,
    output logic [7:0]        rsp_data,
    output logic              rsp_hit,
    output logic [CNT_W-1:0]  hit_count,
    output logic [CNT_W-1:0]  miss_count
);
    import rcache_pkg::*;

    localparam int OFF_W    = $clog2(BLK_BYTES);
    localparam int SETS     = LINES / WAYS;
    localparam int IDX_BITS = $clog2(SETS);
    localparam int SET_W    = (SETS > 1) ? IDX_BITS : 1;
    localparam int WAY_W    = (WAYS > 1) ? $clog2(WAYS) : 1;
    localparam int TAG_W    = ADDR_W - OFF_W - IDX_BITS;
    localparam int LINE_W   = 8 * BLK_BYTES;
    localparam int BLK_AW   = ADDR_W - OFF_W;
    localparam int FILL_CYC = FIRST_CYC + NEXT_CYC * (BLK_BYTES - 1);
    localparam int TMR_MAX  = (FILL_CYC > LOOKUP_CYC) ? FILL_CYC : LOOKUP_CYC;
    localparam int TMR_W    = $clog2(TMR_MAX + 1);

    cstate_t state, nxt;

    logic [ADDR_W-1:0] addr_q;
    logic [TMR_W-1:0]  tmr;
    logic [7:0]        res_data_q;
    logic              res_hit_q;
    logic [CNT_W-1:0]  hit_cnt, miss_cnt;

    logic [SET_W-1:0]  set_idx;
    logic [TAG_W-1:0]  look_tag;
    logic [OFF_W-1:0]  offset;
    logic              hit;
    logic [WAY_W-1:0]  hit_way, victim_way;
    logic [LINE_W-1:0] rd_line, fill_line;
    logic              lookup_end, fill_end;
    logic              touch_en, fill_we;
    logic [WAY_W-1:0]  touch_way;

    // Address split
    assign set_idx  = SET_W'((32'(addr_q) >> OFF_W) % SETS);
    assign look_tag = TAG_W'(32'(addr_q) >> (OFF_W + IDX_BITS));
    assign offset   = addr_q[OFF_W-1:0];

    assign lookup_end = (state == ST_LOOKUP) && (tmr == TMR_W'(LOOKUP_CYC - 1));
    assign fill_end   = (state == ST_FILL)   && (tmr == TMR_W'(FILL_CYC - 1));

    assign touch_en  = (lookup_end && hit) || fill_end;
    assign fill_we   = fill_end;
    assign touch_way = fill_end ? victim_way : hit_way;

    rcache_store #(
        .LINES  (LINES),
        .WAYS   (WAYS),
        .TAG_W  (TAG_W),
        .LINE_W (LINE_W)
    ) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_idx    (set_idx),
        .look_tag   (look_tag),
        .hit        (hit),
        .hit_way    (hit_way),
        .rd_line    (rd_line),
        .victim_way (victim_way),
        .touch_en   (touch_en),
        .touch_way  (touch_way),
        .fill_we    (fill_we),
        .fill_tag   (look_tag),
        .fill_line  (fill_line)
    );

    rcache_backing #(
        .ADDR_W    (ADDR_W),
        .BLK_BYTES (BLK_BYTES)
    ) u_backing (
        .blk_addr (addr_q[ADDR_W-1:OFF_W]),
        .line     (fill_line)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Next state
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (req_valid)  nxt = ST_LOOKUP;
            ST_LOOKUP: if (lookup_end) nxt = hit ? ST_RESP : ST_FILL;
            ST_FILL:   if (fill_end)   nxt = ST_RESP;
            ST_RESP:                   nxt = ST_IDLE;
            default:                   nxt = ST_IDLE;
        endcase
    end

    // Datapath: timer, captured address, result, counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q     <= '0;
            tmr        <= '0;
            res_data_q <= '0;
            res_hit_q  <= 1'b0;
            hit_cnt    <= '0;
            miss_cnt   <= '0;
        end else begin
            if (nxt != state) tmr <= '0;
            else              tmr <= tmr + 1'b1;
            if (state == ST_IDLE && req_valid) addr_q <= req_addr;
            if (lookup_end && hit) begin
                res_data_q <= 8'(rd_line >> {offset, 3'b000});
                res_hit_q  <= 1'b1;
                if (hit_cnt != '1) hit_cnt <= hit_cnt + 1'b1;
            end
            if (fill_end) begin
                res_data_q <= 8'(fill_line >> {offset, 3'b000});
                res_hit_q  <= 1'b0;
                if (miss_cnt != '1) miss_cnt <= miss_cnt + 1'b1;
            end
        end
    end

    // Outputs
    always_comb begin
        rsp_done   = (state == ST_RESP);
        rsp_data   = rsp_done ? res_data_q : 8'h00;
        rsp_hit    = rsp_done && res_hit_q;
        hit_count  = hit_cnt;
        miss_count = miss_cnt;
    end

    // R8: done is a single-cycle pulse
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

    // R10: hit counter steps by one (or holds at max) with each hit result
    a_r10_hit_step: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_done && rsp_hit) |-> ((hit_count == $past(hit_count) + 1'b1) ||
                                   (hit_count == '1 && $past(hit_count) == '1)));

    // R10: miss counter steps by one (or holds at max) with each miss result
    a_r10_miss_step: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_done && !rsp_hit) |-> ((miss_count == $past(miss_count) + 1'b1) ||
                                    (miss_count == '1 && $past(miss_count) == '1)));

    // R10: counters never go down
    a_r10_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (hit_count >= $past(hit_count)) && (miss_count >= $past(miss_count)));

    // R9: captured address holds while busy
    a_r9_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOOKUP || state == ST_FILL) |=> $stable(addr_q));

endmodule

// File: tb/tb_assoc_read_cache.sv
module tb_assoc_read_cache;

    localparam int CLK_PERIOD = 10;
    localparam int HIT_LAT    = 3;
    localparam int MISS_LAT   = 3 + 50 + 3;
    localparam int NTR        = 11;
    // Entry: {address, hit in WAYS=1, hit in WAYS=2, hit in WAYS=4}
    localparam logic [7:0] TRACE [NTR] = '{
        {5'd1,  3'b000}, {5'd5,  3'b000}, {5'd1,  3'b111}, {5'd4,  3'b111},
        {5'd0,  3'b111}, {5'd12, 3'b000}, {5'd5,  3'b001}, {5'd12, 3'b011},
        {5'd5,  3'b011}, {5'd12, 3'b011}, {5'd5,  3'b011}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [4:0] req_addr = '0;

    logic [2:0] done_w, hit_w;
    logic [7:0] data_w [3];
    logic [7:0] hc_w [3];
    logic [7:0] mc_w [3];

    int checks = 0;
    int errors = 0;

    logic [7:0] r_data [3];
    logic       r_hit [3];
    int         r_lat [3];

    always #(CLK_PERIOD/2) clk = ~clk;

    assoc_read_cache #(.WAYS(1)) dut_dm (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .rsp_done(done_w[0]), .rsp_data(data_w[0]), .rsp_hit(hit_w[0]),
        .hit_count(hc_w[0]), .miss_count(mc_w[0]));

    assoc_read_cache #(.WAYS(2)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .rsp_done(done_w[1]), .rsp_data(data_w[1]), .rsp_hit(hit_w[1]),
        .hit_count(hc_w[1]), .miss_count(mc_w[1]));

    assoc_read_cache #(.WAYS(4)) dut_fa (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .rsp_done(done_w[2]), .rsp_data(data_w[2]), .rsp_hit(hit_w[2]),
        .hit_count(hc_w[2]), .miss_count(mc_w[2]));

    function automatic logic [7:0] exp_byte(input int a);
        return 8'((100 + 10 * a) % 256);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // One load to all three instances; poke re-raises the strobe while busy
    task automatic do_load(input logic [4:0] a, input bit poke);
        int  n;
        bit  got [3];
        bit  twice;
        twice = 1'b0;
        for (int i = 0; i < 3; i++) got[i] = 1'b0;
        req_addr  = a;
        req_valid = 1'b1;
        @(posedge clk);
        n = 1;
        @(negedge clk);
        req_valid = 1'b0;
        while (!(got[0] && got[1] && got[2]) && n < 400) begin
            for (int i = 0; i < 3; i++) begin
                if (done_w[i] && got[i]) twice = 1'b1;
                if (done_w[i] && !got[i]) begin
                    got[i]   = 1'b1;
                    r_data[i] = data_w[i];
                    r_hit[i]  = hit_w[i];
                    r_lat[i]  = n;
                end
            end
            if (poke && n == 6) begin
                req_valid = 1'b1;
                req_addr  = 5'd1;
            end else begin
                req_valid = 1'b0;
            end
            if (!(got[0] && got[1] && got[2])) begin
                @(posedge clk);
                n++;
                @(negedge clk);
            end
        end
        req_valid = 1'b0;
        chk(got[0] && got[1] && got[2], "R8 response arrives", n, MISS_LAT);
        @(negedge clk);
        chk(done_w == 3'b000 && !twice, "R8 done one cycle", int'(done_w), 0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        int hits_before [3];
        int miss_before [3];
        bit exp_hit;

        repeat (3) @(negedge clk);
        // R1: reset state
        for (int i = 0; i < 3; i++) begin
            chk(done_w[i] == 0 && hit_w[i] == 0 && data_w[i] == 0, "R1 outputs idle", int'(data_w[i]), 0);
            chk(hc_w[i] == 0 && mc_w[i] == 0, "R1 counters clear", int'(hc_w[i]) + int'(mc_w[i]), 0);
        end
        rst_n = 1'b1;
        @(negedge clk);

        // R6 trace, also R2 R3 R4 R7
        for (int t = 0; t < NTR; t++) begin
            do_load(TRACE[t][7:3], 1'b0);
            for (int i = 0; i < 3; i++) begin
                exp_hit = TRACE[t][2 - i];
                chk(r_hit[i] == exp_hit, "R2 R6 hit flag per placement", int'(r_hit[i]), int'(exp_hit));
                chk(r_data[i] == exp_byte(int'(TRACE[t][7:3])), "R3 R4 returned byte",
                    int'(r_data[i]), int'(exp_byte(int'(TRACE[t][7:3]))));
                chk(r_lat[i] == (exp_hit ? HIT_LAT : MISS_LAT), "R7 latency",
                    r_lat[i], exp_hit ? HIT_LAT : MISS_LAT);
            end
        end
        chk(hc_w[0] == 3 && mc_w[0] == 8, "R6 direct-mapped counts", int'(hc_w[0]), 3);
        chk(hc_w[1] == 7 && mc_w[1] == 4, "R6 two-way counts", int'(hc_w[1]), 7);
        chk(hc_w[2] == 8 && mc_w[2] == 3, "R6 fully associative counts", int'(hc_w[2]), 8);

        // R5: two-way LRU eviction; fully associative fills the free line
        do_load(5'd17, 1'b0);
        chk(r_hit[1] == 0, "R5 two-way 17 misses", int'(r_hit[1]), 0);
        chk(r_hit[2] == 0, "R5 full 17 misses", int'(r_hit[2]), 0);
        do_load(5'd5, 1'b0);
        chk(r_hit[1] == 1, "R5 two-way keeps recent block 4", int'(r_hit[1]), 1);
        do_load(5'd12, 1'b0);
        chk(r_hit[1] == 0, "R5 two-way evicted LRU block 12", int'(r_hit[1]), 0);
        chk(r_hit[2] == 1, "R5 full keeps block 12", int'(r_hit[2]), 1);
        do_load(5'd0, 1'b0);
        chk(r_hit[2] == 1, "R5 full used invalid line first", int'(r_hit[2]), 1);
        chk(r_data[1] == 8'd100, "R4 refill byte 0", int'(r_data[1]), 100);

        // R10 R11: saturate hit counters with repeated hits to address 0
        for (int i = 0; i < 3; i++) miss_before[i] = int'(mc_w[i]);
        for (int k = 0; k < 260; k++) begin
            do_load(5'd0, 1'b0);
            if (k % 50 == 0) begin
                for (int i = 0; i < 3; i++) begin
                    chk(r_hit[i] == 1 && r_data[i] == 8'd100, "R11 repeated hit same byte",
                        int'(r_data[i]), 100);
                end
            end
        end
        for (int i = 0; i < 3; i++) begin
            chk(hc_w[i] == 8'd255, "R10 hit counter saturates", int'(hc_w[i]), 255);
            chk(int'(mc_w[i]) == miss_before[i], "R10 miss counter unchanged", int'(mc_w[i]), miss_before[i]);
        end

        // R9: strobe while busy is ignored; R4 high address byte
        for (int i = 0; i < 3; i++) begin
            hits_before[i] = int'(hc_w[i]);
            miss_before[i] = int'(mc_w[i]);
        end
        do_load(5'd20, 1'b1);
        for (int i = 0; i < 3; i++) begin
            chk(r_data[i] == 8'd44, "R4 byte 20 wraps to 44", int'(r_data[i]), 44);
            chk(r_hit[i] == 0, "R9 first load misses", int'(r_hit[i]), 0);
        end
        for (int c = 0; c < 70; c++) begin
            if (done_w != 3'b000) chk(1'b0, "R9 no extra response", int'(done_w), 0);
            @(negedge clk);
        end
        for (int i = 0; i < 3; i++) begin
            chk(int'(mc_w[i]) == miss_before[i] + 1, "R9 one miss counted", int'(mc_w[i]), miss_before[i] + 1);
            chk(int'(hc_w[i]) == hits_before[i], "R9 no hit counted", int'(hc_w[i]), hits_before[i]);
        end
        do_load(5'd21, 1'b0);
        chk(r_hit[1] == 1 && r_data[1] == 8'd54, "R3 odd byte of filled pair", int'(r_data[1]), 54);

        // R1: reset clears valid lines and counters
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        for (int i = 0; i < 3; i++) begin
            chk(hc_w[i] == 0 && mc_w[i] == 0, "R1 counters cleared again", int'(hc_w[i]), 0);
        end
        do_load(5'd1, 1'b0);
        for (int i = 0; i < 3; i++) begin
            chk(r_hit[i] == 0 && r_data[i] == 8'd110, "R1 lines invalid after reset", int'(r_hit[i]), 0);
        end

        finish_run();
    end

endmodule